// File: doc/BRIEF.md
# Four-Accumulator Pipelined Multiply-Accumulate Unit

This block is a multiply-accumulate datapath that accepts one operation on any clock cycle and never stalls. Each operation brings two 32-bit operands, an operation kind and a 2-bit accumulator index. The block multiplies the operands in a 32x32 array. It then either returns the product alone or adds the product to, or subtracts it from, one of four 48-bit accumulators. Each accumulator holds a 40-bit product field under 8 guard bits.

Three configuration inputs are sampled with each operation and travel with it through the pipeline. They choose unsigned integer, signed integer or signed fractional (Q31) operands, and they choose whether an overflow clamps the result. Each accumulator has a sticky overflow flag. A separate port writes an accumulator directly, and that write is ordered behind every operation already accepted. A combinational port reads back any accumulator.

Top module: `mac4_unit`

## Requirements
- R1: An operation accepted at clock edge k (in_valid high) shows res_valid high with its res_data after edge k+3, and a new operation may be accepted on every edge.
- R2: op_kind encoding: 2'b00 and 2'b11 multiply, 2'b01 add to accumulator, 2'b10 subtract from accumulator. A multiply returns the 48-bit product term and leaves every accumulator unchanged.
- R3: acc_sel picks one of four accumulators. For add or subtract, res_data is the new value of that accumulator.
- R4: With cfg_frac=0, cfg_signed=1 treats the operands as two's complement and cfg_signed=0 treats them as unsigned. The product term is bits [39:0] of the 64-bit product, sign-extended (signed) or zero-extended (unsigned) to 48 bits.
- R5: With cfg_frac=1, the operands are signed Q31 values. The product term is bits [62:23] of the 64-bit signed product (the product shifted left one place with the low bits dropped), sign-extended to 48 bits.
- R6: The accumulator is signed in signed and fractional modes and unsigned in unsigned mode. A result outside the 48-bit range sets the sticky bit ovf_flags[i] for that accumulator. With cfg_sat=0 the value wraps modulo 2^48.
- R7: With cfg_sat=1, an overflowing result clamps. In signed modes it clamps to 0x7FFF_FFFF_FFFF or 0x8000_0000_0000. In unsigned mode an add clamps to all ones and a subtract clamps to zero.
- R8: Back-to-back operations on one accumulator each build on the previous result, with no stall.
- R9: acc_wr_en at edge k loads acc_wr_data into accumulator acc_wr_sel at edge k+3. The load follows any operation accepted at or before edge k, and it clears that accumulator's overflow flag.
- R10: acc_rd_data always shows the accumulator chosen by acc_rd_sel.
- R11: Reset (rst_n low) clears all accumulators, all overflow flags and res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_kind | input | 2 | Multiply / add / subtract selector |
| acc_sel | input | 2 | Target accumulator |
| cfg_frac | input | 1 | Signed fractional operands |
| cfg_signed | input | 1 | Signed integer operands when not fractional |
| cfg_sat | input | 1 | Clamp on overflow |
| acc_wr_en | input | 1 | Direct accumulator load |
| acc_wr_sel | input | 2 | Accumulator to load |
| acc_wr_data | input | 48 | Load value |
| acc_rd_sel | input | 2 | Accumulator to read |
| acc_rd_data | output | 48 | Selected accumulator value |
| ovf_flags | output | 4 | Sticky overflow flag per accumulator |
| res_valid | output | 1 | Result present |
| res_data | output | 48 | Product term or new accumulator value |

## Verification
The assertions check three things on every cycle. They check the fixed four-edge spacing between in_valid and res_valid, and that a multiply leaves the accumulator file untouched. They also check that an overflow flag only rises on an accumulate to that index and only falls when a direct load reaches it.

The bench scenarios cover the arithmetic values that the assertions cannot reach: fractional alignment, unsigned and signed extension, wrap versus clamp at both ends of the range, and the ordering of a direct load behind an operation issued in the same cycle.

// File: rtl/mac4_pkg.sv
package mac4_pkg;
  localparam int OPW   = 32;
  localparam int FLDW  = 40;
  localparam int ACCW  = 48;
  localparam int NACC  = 4;
  localparam int LAT   = 4;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_MULX = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    MD_UNS  = 2'b00,
    MD_SGN  = 2'b01,
    MD_FRAC = 2'b10
  } mode_e;
endpackage

// File: rtl/mac4_mult.sv
module mac4_mult #(
  parameter int OPW = 32
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic             is_signed,
  output logic [2*OPW-1:0] prod
);
  logic signed [OPW:0]     ax, bx;
  logic signed [2*OPW+1:0] full;

  always_comb begin
    ax   = {is_signed & a[OPW-1], a};
    bx   = {is_signed & b[OPW-1], b};
    full = ax * bx;
    prod = full[2*OPW-1:0];
  end
endmodule

// File: rtl/mac4_align.sv
module mac4_align
  import mac4_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int FLDW = 40,
  parameter int ACCW = 48
) (
  input  logic [2*OPW-1:0] prod,
  input  mode_e            mode,
  output logic [ACCW-1:0]  term
);
  localparam int GUARD = ACCW - FLDW;
  localparam int FTOP  = 2*OPW - 2;

  logic [FLDW-1:0] fld;

  always_comb begin
    if (mode == MD_FRAC) fld = prod[FTOP -: FLDW];
    else                 fld = prod[FLDW-1:0];
    if (mode == MD_UNS)  term = {{GUARD{1'b0}}, fld};
    else                 term = {{GUARD{fld[FLDW-1]}}, fld};
  end
endmodule

// File: rtl/mac4_accum.sv
module mac4_accum #(
  parameter int ACCW = 48
) (
  input  logic [ACCW-1:0] acc_in,
  input  logic [ACCW-1:0] term,
  input  logic            sub,
  input  logic            is_signed,
  input  logic            sat,
  output logic [ACCW-1:0] acc_out,
  output logic            ovf
);
  localparam logic [ACCW-1:0] SMAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] SMIN = {1'b1, {(ACCW-1){1'b0}}};

  logic [ACCW:0] ae, te, s;

  always_comb begin
    ae  = {is_signed & acc_in[ACCW-1], acc_in};
    te  = {is_signed & term[ACCW-1], term};
    s   = sub ? (ae - te) : (ae + te);
    ovf = is_signed ? (s[ACCW] ^ s[ACCW-1]) : s[ACCW];
    if (ovf && sat) begin
      if (is_signed) acc_out = s[ACCW] ? SMIN : SMAX;
      else           acc_out = sub ? '0 : '1;
    end else begin
      acc_out = s[ACCW-1:0];
    end
  end
endmodule

// File: rtl/mac4_unit.sv
module mac4_unit
  import mac4_pkg::*;
#(
  parameter int OPW  = mac4_pkg::OPW,
  parameter int FLDW = mac4_pkg::FLDW,
  parameter int ACCW = mac4_pkg::ACCW,
  parameter int NACC = mac4_pkg::NACC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [OPW-1:0]           op_a,
  input  logic [OPW-1:0]           op_b,
  input  logic [1:0]               op_kind,
  input  logic [$clog2(NACC)-1:0]  acc_sel,
  input  logic                     cfg_frac,
  input  logic                     cfg_signed,
  input  logic                     cfg_sat,
  input  logic                     acc_wr_en,
  input  logic [$clog2(NACC)-1:0]  acc_wr_sel,
  input  logic [ACCW-1:0]          acc_wr_data,
  input  logic [$clog2(NACC)-1:0]  acc_rd_sel,
  output logic [ACCW-1:0]          acc_rd_data,
  output logic [NACC-1:0]          ovf_flags,
  output logic                     res_valid,
  output logic [ACCW-1:0]          res_data
);
  localparam int SELW = $clog2(NACC);
  localparam int PW   = 2*OPW;

  // stage 1: operand capture
  logic            s1_v, s1_sat;
  logic [OPW-1:0]  s1_a, s1_b;
  op_e             s1_kind;
  mode_e           s1_mode;
  logic [SELW-1:0] s1_sel;
  // stage 2: raw product
  logic            s2_v, s2_sat;
  logic [PW-1:0]   s2_prod;
  op_e             s2_kind;
  mode_e           s2_mode;
  logic [SELW-1:0] s2_sel;
  // stage 3: aligned product term
  logic            s3_v, s3_sat;
  logic [ACCW-1:0] s3_term;
  op_e             s3_kind;
  mode_e           s3_mode;
  logic [SELW-1:0] s3_sel;
  // direct-load delay line
  logic            w1_en, w2_en, w3_en;
  logic [SELW-1:0] w1_sel, w2_sel, w3_sel;
  logic [ACCW-1:0] w1_dat, w2_dat, w3_dat;
  // architectural state
  logic [NACC-1:0][ACCW-1:0] acc_q, acc_d;
  logic [NACC-1:0]           ovf_q, ovf_d;
  logic                      rv_q;
  logic [ACCW-1:0]           rd_q, rd_d;

  mode_e           in_mode;
  logic [PW-1:0]   prod_c;
  logic [ACCW-1:0] term_c, sum_c;
  logic            ovf_c, s3_acc, acc_en;

  assign in_mode = cfg_frac ? MD_FRAC : (cfg_signed ? MD_SGN : MD_UNS);
  assign s3_acc  = (s3_kind == OP_ADD) || (s3_kind == OP_SUB);

  mac4_mult #(.OPW(OPW)) u_mult (
    .a(s1_a), .b(s1_b), .is_signed(s1_mode != MD_UNS), .prod(prod_c)
  );

  mac4_align #(.OPW(OPW), .FLDW(FLDW), .ACCW(ACCW)) u_align (
    .prod(s2_prod), .mode(s2_mode), .term(term_c)
  );

  // accumulate reads the live register: the previous op already wrote it
  mac4_accum #(.ACCW(ACCW)) u_accum (
    .acc_in(acc_q[s3_sel]), .term(s3_term), .sub(s3_kind == OP_SUB),
    .is_signed(s3_mode != MD_UNS), .sat(s3_sat),
    .acc_out(sum_c), .ovf(ovf_c)
  );

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    rd_d  = s3_acc ? sum_c : s3_term;
    if (s3_v && s3_acc) begin
      acc_d[s3_sel] = sum_c;
      if (ovf_c) ovf_d[s3_sel] = 1'b1;
    end
    if (w3_en) begin
      acc_d[w3_sel] = w3_dat;
      ovf_d[w3_sel] = 1'b0;
    end
    acc_en = (s3_v && s3_acc) || w3_en;
  end

  // valid bits and direct-load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0; rv_q <= 1'b0;
      w1_en <= 1'b0; w2_en <= 1'b0; w3_en <= 1'b0;
      acc_q <= '0; ovf_q <= '0;
    end else begin
      s1_v <= in_valid; s2_v <= s1_v; s3_v <= s2_v; rv_q <= s3_v;
      w1_en <= acc_wr_en; w2_en <= w1_en; w3_en <= w2_en;
      if (acc_en) begin
        acc_q <= acc_d;
        ovf_q <= ovf_d;
      end
    end
  end

  // payload registers, clock-enabled by the valid of the stage feeding them
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_a <= op_a; s1_b <= op_b; s1_kind <= op_e'(op_kind);
      s1_sel <= acc_sel; s1_mode <= in_mode; s1_sat <= cfg_sat;
    end
    if (s1_v) begin
      s2_prod <= prod_c; s2_kind <= s1_kind; s2_sel <= s1_sel;
      s2_mode <= s1_mode; s2_sat <= s1_sat;
    end
    if (s2_v) begin
      s3_term <= term_c; s3_kind <= s2_kind; s3_sel <= s2_sel;
      s3_mode <= s2_mode; s3_sat <= s2_sat;
    end
    if (s3_v) rd_q <= rd_d;
    if (acc_wr_en) begin w1_sel <= acc_wr_sel; w1_dat <= acc_wr_data; end
    if (w1_en) begin w2_sel <= w1_sel; w2_dat <= w1_dat; end
    if (w2_en) begin w3_sel <= w2_sel; w3_dat <= w2_dat; end
  end

  assign acc_rd_data = acc_q[acc_rd_sel];
  assign ovf_flags   = ovf_q;
  assign res_valid   = rv_q;
  assign res_data    = rd_q;

  // ---------------- assertions ----------------
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   age_q <= '0;
    else if (age_q != 3'(LAT))    age_q <= age_q + 3'd1;
  end

  assert_res_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'(LAT)) |-> (res_valid == $past(in_valid, 4)));

  assert_mul_keeps_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_v && !s3_acc && !w3_en) |=> $stable(acc_q));

  for (genvar i = 0; i < NACC; i++) begin : g_flag_chk
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_q[i]) |-> $past(w3_en && (w3_sel == SELW'(i))));
    assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q[i]) |-> $past(s3_v && s3_acc && (s3_sel == SELW'(i))));
  end
endmodule

// File: tb/mac4_unit_test.sv
module mac4_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, cfg_frac, cfg_signed, cfg_sat, acc_wr_en;
  logic [31:0] op_a, op_b;
  logic [1:0]  op_kind, acc_sel, acc_wr_sel, acc_rd_sel;
  logic [47:0] acc_wr_data, acc_rd_data, res_data;
  logic [3:0]  ovf_flags;
  logic        res_valid;

  mac4_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [47:0] exp_data[$];
  int          exp_cyc[$];
  string       exp_tag[$];

  logic [47:0] m_acc [4];
  logic [3:0]  m_ovf;

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // product term from the requirements (R4, R5)
  function automatic logic [47:0] term_of(input logic [31:0] a, input logic [31:0] b,
                                          input logic frac, input logic sgn);
    logic [63:0] p;
    if (frac || sgn) p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    else             p = {32'b0, a} * {32'b0, b};
    if (frac)     return {{8{p[62]}}, p[62:23]};
    else if (sgn) return {{8{p[39]}}, p[39:0]};
    else          return {8'b0, p[39:0]};
  endfunction

  // accumulate model with 64-bit range arithmetic (R6, R7)
  function automatic logic [47:0] acc_step(input logic [47:0] acc, input logic [47:0] t,
      input logic sub, input logic sgn, input logic sat, output logic ovf);
    longint x, y, r;
    if (sgn) begin
      x = longint'($signed(acc)); y = longint'($signed(t));
      r = sub ? x - y : x + y;
      ovf = (r > 64'sh7FFF_FFFF_FFFF) || (r < -64'sh8000_0000_0000);
      if (ovf && sat) return (r < 0) ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
    end else begin
      x = longint'({16'b0, acc}); y = longint'({16'b0, t});
      r = sub ? x - y : x + y;
      ovf = (r < 0) || (r > 64'sh0000_FFFF_FFFF_FFFF);
      if (ovf && sat) return sub ? 48'h0 : 48'hFFFF_FFFF_FFFF;
    end
    return r[47:0];
  endfunction

  task automatic issue(input logic v, input logic [1:0] kind, input logic [1:0] sel,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic frac, input logic sgn, input logic sat,
                       input logic we, input logic [1:0] wsel, input logic [47:0] wdat,
                       input string tag);
    logic [47:0] t, r;
    logic o;
    @(negedge clk);
    in_valid = v; op_kind = kind; acc_sel = sel; op_a = a; op_b = b;
    cfg_frac = frac; cfg_signed = sgn; cfg_sat = sat;
    acc_wr_en = we; acc_wr_sel = wsel; acc_wr_data = wdat;
    if (v) begin
      t = term_of(a, b, frac, sgn);
      if (kind == 2'b01 || kind == 2'b10) begin
        r = acc_step(m_acc[sel], t, kind == 2'b10, frac || sgn, sat, o);
        m_acc[sel] = r;
        if (o) m_ovf[sel] = 1'b1;
      end else r = t;
      exp_data.push_back(r); exp_cyc.push_back(cyc + 4); exp_tag.push_back(tag);
    end
    if (we) begin m_acc[wsel] = wdat; m_ovf[wsel] = 1'b0; end
  endtask

  task automatic op(input logic [1:0] kind, input logic [1:0] sel, input logic [31:0] a,
                    input logic [31:0] b, input logic frac, input logic sgn,
                    input logic sat, input string tag);
    issue(1'b1, kind, sel, a, b, frac, sgn, sat, 1'b0, 2'd0, 48'd0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [47:0] d);
    issue(1'b0, 2'b00, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, sel, d, "R9");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      issue(1'b0, 2'b00, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 48'd0, "");
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_data.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1: unexpected result %h, expected none", res_data);
      end else begin
        string tg;
        int    ec;
        tg = exp_tag.pop_front();
        ec = exp_cyc.pop_front();
        check(tg, res_data, exp_data.pop_front());
        check("R1 latency", 48'(cyc), 48'(ec));
      end
    end
  end

  task automatic read_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      acc_rd_sel = 2'(i);
      #1;
      check(tag, acc_rd_data, m_acc[i]);
    end
    check({tag, " flags"}, 48'(ovf_flags), 48'(m_ovf));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; acc_wr_en = 1'b0; op_a = '0; op_b = '0;
    op_kind = '0; acc_sel = '0; cfg_frac = 1'b0; cfg_signed = 1'b0; cfg_sat = 1'b0;
    acc_wr_sel = '0; acc_wr_data = '0; acc_rd_sel = '0;
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    m_ovf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state (R10 read port)
    check("R11 res_valid", 48'(res_valid), 48'd0);
    read_all("R11 R10 reset");

    // R2 R4 multiplies: signed, unsigned; R5 fractional
    op(2'b00, 2'd0, 32'hFFFF_FFFD, 32'd7, 1'b0, 1'b1, 1'b0, "R4 signed mul");
    op(2'b11, 2'd1, 32'hFFFF_FFFF, 32'd2, 1'b0, 1'b0, 1'b0, "R4 unsigned mul");
    op(2'b00, 2'd2, 32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, "R5 frac mul");
    op(2'b00, 2'd3, 32'hC000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, "R5 frac neg mul");

    // R3 R8 back-to-back accumulates on one accumulator, interleaved
    op(2'b01, 2'd1, 32'd1000, 32'd3, 1'b0, 1'b1, 1'b0, "R8 add");
    op(2'b01, 2'd1, 32'hFFFF_FFFB, 32'd4, 1'b0, 1'b1, 1'b0, "R8 add neg");
    op(2'b10, 2'd1, 32'd7, 32'd7, 1'b0, 1'b1, 1'b0, "R8 sub");
    op(2'b01, 2'd2, 32'd100, 32'd100, 1'b0, 1'b1, 1'b0, "R3 other acc");
    op(2'b01, 2'd1, 32'd2, 32'd2, 1'b0, 1'b1, 1'b0, "R3 add");
    op(2'b00, 2'd1, 32'd9, 32'd9, 1'b0, 1'b1, 1'b0, "R2 mul no acc change");
    op(2'b01, 2'd3, 32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, "R5 frac acc");
    op(2'b01, 2'd3, 32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, "R5 frac acc 2");
    idle(6);
    read_all("R2 R3 accs");

    // R6 wrap, R7 clamps, R9 load then op next cycle
    wr(2'd2, 48'h7FFF_FFFF_FFFF);
    op(2'b01, 2'd2, 32'd1, 32'd1, 1'b0, 1'b1, 1'b0, "R6 wrap");
    wr(2'd3, 48'h7FFF_FFFF_FFF0);
    op(2'b01, 2'd3, 32'd16, 32'd16, 1'b0, 1'b1, 1'b1, "R7 clamp max");
    wr(2'd1, 48'h8000_0000_0000);
    op(2'b10, 2'd1, 32'd1, 32'd1, 1'b0, 1'b1, 1'b1, "R7 clamp min");
    wr(2'd0, 48'd5);
    op(2'b10, 2'd0, 32'd2, 32'd3, 1'b0, 1'b0, 1'b1, "R7 unsigned floor");
    wr(2'd0, 48'hFFFF_FFFF_FFF0);
    op(2'b01, 2'd0, 32'h10, 32'd1, 1'b0, 1'b0, 1'b1, "R7 unsigned ceiling");
    idle(6);
    read_all("R6 R7 saturation");

    // R9 load in the same cycle as an op on the same accumulator: load wins, flag clears
    issue(1'b1, 2'b01, 2'd0, 32'd3, 32'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 48'h123, "R9 same-cycle op");
    op(2'b01, 2'd0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0, "R9 after load");
    idle(6);
    read_all("R9 load order");

    checks++;
    if (exp_data.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d results missing, expected 0", exp_data.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule